// File: doc/BRIEF.md
# Three-Phase Carrier PWM Generator

This block drives three pulse-width-modulated phase commands (U, V and W) from one shared carrier. The carrier is a counter that steps once per `tick_en` pulse. It runs in one of two modes. In triangle mode it counts up from zero to a programmed period value and then back down to zero. In sawtooth mode it counts up to the period value and then wraps to zero. Each phase compares the carrier against its own width setting, so its pulse lasts a programmable number of ticks within every carrier cycle. The outputs are plain active-high phase commands, meant to feed a dead-time stage further down the chip.

Carrier settings are held in a staging stage and copied into working registers only at a carrier boundary. The boundary is the valley of the triangle or the wrap of the sawtooth. The staged settings are:
- the mode and the period value;
- each phase's primary width and secondary width;
- the option to use the secondary width on the falling slope;
- the per-phase forced levels.

Because of this staging, a pulse is never cut short part way through a cycle. A carrier interrupt pulse can be thinned so that it fires only on every Nth boundary.

The carrier state machine has four states:
- `CS_IDLE`: after reset, waiting for the first tick.
- `CS_RISE`: triangle rising slope.
- `CS_FALL`: triangle falling slope.
- `CS_RAMP`: sawtooth ramp.

Its transitions are:
- start: `CS_IDLE` to `CS_RISE` or to `CS_RAMP` on the first tick.
- peak turn: `CS_RISE` to `CS_FALL` on a tick while the count equals the period.
- valley wrap: `CS_FALL` to the mode's entry state on a tick while the count is zero.
- ramp wrap: `CS_RAMP` to the mode's entry state on a tick while the count equals the period.

Top module: `tri_phase_pwm`

## Requirements
- R1: In triangle mode, with period setting m, the carrier holds positions 0,1,…,m on the rising slope and then m,m−1,…,0 on the falling slope. A full cycle is 2(m+1) ticks, and the boundary is the tick that leaves position 0 of the falling slope.
- R2: In sawtooth mode the carrier counts 0..m and wraps to 0. A cycle is m+1 ticks, and the boundary is the tick that leaves position m.
- R3: The carrier moves only on a cycle where `tick_en` is 1. After reset all phase outputs and `carrier_irq` stay 0 until the first tick. That first tick loads every staged setting and places the carrier at position 0.
- R4: In triangle mode a non-forced phase with width n is high whenever position + n > m. This gives 2n high ticks per cycle, centred on the peak.
- R5: In sawtooth mode a non-forced phase with primary width n is high whenever position < n, which is n ticks per cycle.
- R6: When `dual_en` is 1 at a boundary, each phase uses its secondary width on the falling slope of the next triangle cycle. Otherwise it uses its primary width on both slopes.
- R7: A write with `wid_we`=1 stores `wid_data` in a staging register. `wid_sel` 0, 1 and 2 address U, V and W; `wid_sel`=3 is ignored. `wid_alt`=1 selects the secondary width. A staged width takes effect only at the next boundary.
- R8: A width of 0 keeps a non-forced phase low for the whole cycle. A width of m+1 or more keeps it high for the whole cycle.
- R9: If `force_en[i]` is 1 at a boundary, phase i (bit 0=U, 1=V, 2=W) outputs `force_lvl[i]` for the entire following cycle.
- R10: `carrier_irq` is a one-clock pulse in the clock after every Nth boundary. N is the decimation setting, 1..15, and a setting of 0 behaves as 1. The start tick is not a boundary.
- R11: A write with `div_we`=1 loads `div_val` and restarts the boundary count. The first interrupt after the write follows the Nth boundary after it, and `carrier_irq` is 0 in the clock after the write.
- R12: `mode_tri` and `period_m` are sampled only at the start tick and at boundaries, so a cycle always runs with one mode and one period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Carrier step enable (prescaled count source) |
| mode_tri | input | 1 | 1 = triangle carrier, 0 = sawtooth |
| period_m | input | WIDTH | Carrier period setting m |
| dual_en | input | 1 | Use secondary widths on the falling slope |
| force_en | input | 3 | Per-phase force request, bit 0=U, 1=V, 2=W |
| force_lvl | input | 3 | Per-phase forced level |
| wid_we | input | 1 | Width staging write strobe |
| wid_sel | input | 2 | Width write target phase (3 = none) |
| wid_alt | input | 1 | 1 = write secondary width |
| wid_data | input | WIDTH | Width value |
| div_we | input | 1 | Interrupt decimation write strobe |
| div_val | input | 4 | Interrupt decimation value |
| pwm_u | output | 1 | Phase U command |
| pwm_v | output | 1 | Phase V command |
| pwm_w | output | 1 | Phase W command |
| carrier_irq | output | 1 | Thinned carrier-cycle interrupt pulse |

## Verification
A wrong carrier count or state shows on the phase outputs within one carrier cycle: the pulse edges move away from the positions that the width and period predict. A working or staged register that loads at the wrong time shows at the first boundary after the write. There, the pulse width, the forced level or the cycle length differs from the expected cycle. A decimation counter that drifts shows only after N boundaries, as an interrupt pulse that is missing or shifted, so the longest sweeps run for at least fifteen boundaries.

// File: rtl/tpp_pkg.sv
package tpp_pkg;

    localparam int NUM_PH = 3;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_RISE = 2'd1,
        CS_FALL = 2'd2,
        CS_RAMP = 2'd3
    } carrier_st_e;

endpackage

// File: rtl/tpp_carrier.sv
module tpp_carrier
    import tpp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         mode_tri_i,
    input  logic [W-1:0] period_i,
    output carrier_st_e  st_o,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] per_o,
    output logic         load_o,
    output logic         wrap_o
);

    carrier_st_e  st_q, st_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] per_q, per_d;
    logic         at_top, at_base;
    carrier_st_e  entry_st;

    assign at_top   = (cnt_q == per_q);
    assign at_base  = (cnt_q == '0);
    assign entry_st = mode_tri_i ? CS_RISE : CS_RAMP;

    // next-state and boundary decode
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        per_d  = per_q;
        load_o = 1'b0;
        wrap_o = 1'b0;
        if (tick_i) begin
            unique case (st_q)
                CS_IDLE: begin
                    st_d   = entry_st;
                    cnt_d  = '0;
                    per_d  = period_i;
                    load_o = 1'b1;
                end
                CS_RISE: begin
                    if (at_top) st_d = CS_FALL;
                    else        cnt_d = cnt_q + 1'b1;
                end
                CS_FALL: begin
                    if (at_base) begin
                        st_d   = entry_st;
                        per_d  = period_i;
                        load_o = 1'b1;
                        wrap_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                CS_RAMP: begin
                    if (at_top) begin
                        st_d   = entry_st;
                        cnt_d  = '0;
                        per_d  = period_i;
                        load_o = 1'b1;
                        wrap_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: st_d = CS_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CS_IDLE;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            per_q <= per_d;
        end
    end

    // outputs
    always_comb begin
        st_o  = st_q;
        cnt_o = cnt_q;
        per_o = per_q;
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CS_IDLE) |-> (cnt_q <= per_q));

    p_peak_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q == CS_RISE && cnt_q == per_q)
        |=> (st_q == CS_FALL && cnt_q == $past(per_q)));

    p_saw_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q == CS_RAMP && cnt_q == per_q) |=> (cnt_q == '0));

    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(cnt_q) && $stable(st_q)));

    p_period_latch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_o && st_q != CS_IDLE) |=> $stable(per_q));

endmodule

// File: rtl/tpp_phase.sv
module tpp_phase
    import tpp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_pri_i,
    input  logic         wr_sec_i,
    input  logic [W-1:0] wdata_i,
    input  logic         dual_i,
    input  logic         force_i,
    input  logic         lvl_i,
    input  logic         load_i,
    input  carrier_st_e  st_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] per_i,
    output logic         pwm_o
);

    logic [W-1:0] stg_pri_q, stg_sec_q;
    logic [W-1:0] act_up_q, act_dn_q;
    logic         frc_q, lvl_q;
    logic [W:0]   sum_up, sum_dn, per_ext;

    // staging registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_pri_q <= '0;
            stg_sec_q <= '0;
        end else begin
            if (wr_pri_i) stg_pri_q <= wdata_i;
            if (wr_sec_i) stg_sec_q <= wdata_i;
        end
    end

    // working registers, loaded at carrier boundaries only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_up_q <= '0;
            act_dn_q <= '0;
            frc_q    <= 1'b0;
            lvl_q    <= 1'b0;
        end else if (load_i) begin
            act_up_q <= stg_pri_q;
            act_dn_q <= dual_i ? stg_sec_q : stg_pri_q;
            frc_q    <= force_i;
            lvl_q    <= lvl_i;
        end
    end

    assign sum_up  = {1'b0, cnt_i} + {1'b0, act_up_q};
    assign sum_dn  = {1'b0, cnt_i} + {1'b0, act_dn_q};
    assign per_ext = {1'b0, per_i};

    always_comb begin
        pwm_o = 1'b0;
        if (st_i != CS_IDLE && frc_q) begin
            pwm_o = lvl_q;
        end else begin
            unique case (st_i)
                CS_IDLE: pwm_o = 1'b0;
                CS_RISE: pwm_o = (sum_up > per_ext);
                CS_FALL: pwm_o = (sum_dn > per_ext);
                CS_RAMP: pwm_o = (cnt_i < act_up_q);
                default: pwm_o = 1'b0;
            endcase
        end
    end

    p_width_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(act_up_q) && $stable(act_dn_q)));

    p_force_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_q && st_i != CS_IDLE && !load_i) |=> $stable(pwm_o));

    p_zero_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frc_q && act_up_q == '0 && (st_i == CS_RISE || st_i == CS_RAMP)) |-> !pwm_o);

endmodule

// File: rtl/tpp_irq_div.sv
module tpp_irq_div #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] div_i,
    input  logic          wrap_i,
    output logic          irq_o
);

    logic [DW-1:0] div_q, seen_q;
    logic [DW:0]   seen_nx, limit;

    assign limit   = (div_q == '0) ? {{DW{1'b0}}, 1'b1} : {1'b0, div_q};
    assign seen_nx = {1'b0, seen_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            seen_q <= '0;
            irq_o  <= 1'b0;
        end else if (wr_i) begin
            div_q  <= div_i;
            seen_q <= '0;
            irq_o  <= 1'b0;
        end else if (wrap_i) begin
            if (seen_nx >= limit) begin
                seen_q <= '0;
                irq_o  <= 1'b1;
            end else begin
                seen_q <= seen_nx[DW-1:0];
                irq_o  <= 1'b0;
            end
        end else begin
            irq_o <= 1'b0;
        end
    end

    p_irq_after_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(wrap_i));

    p_irq_quiet_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !irq_o);

endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm
    import tpp_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             mode_tri,
    input  logic [WIDTH-1:0] period_m,
    input  logic             dual_en,
    input  logic [2:0]       force_en,
    input  logic [2:0]       force_lvl,
    input  logic             wid_we,
    input  logic [1:0]       wid_sel,
    input  logic             wid_alt,
    input  logic [WIDTH-1:0] wid_data,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    output logic             pwm_u,
    output logic             pwm_v,
    output logic             pwm_w,
    output logic             carrier_irq
);

    carrier_st_e        car_st;
    logic [WIDTH-1:0]   car_cnt, car_per;
    logic               car_load, car_wrap;
    logic [NUM_PH-1:0]  pwm_vec;

    tpp_carrier #(.W(WIDTH)) u_carrier (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_en),
        .mode_tri_i (mode_tri),
        .period_i   (period_m),
        .st_o       (car_st),
        .cnt_o      (car_cnt),
        .per_o      (car_per),
        .load_o     (car_load),
        .wrap_o     (car_wrap)
    );

    for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
        logic hit;
        assign hit = wid_we && (wid_sel == 2'(g));
        tpp_phase #(.W(WIDTH)) u_phase (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_pri_i (hit && !wid_alt),
            .wr_sec_i (hit && wid_alt),
            .wdata_i  (wid_data),
            .dual_i   (dual_en),
            .force_i  (force_en[g]),
            .lvl_i    (force_lvl[g]),
            .load_i   (car_load),
            .st_i     (car_st),
            .cnt_i    (car_cnt),
            .per_i    (car_per),
            .pwm_o    (pwm_vec[g])
        );
    end

    tpp_irq_div #(.DW(DIV_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (div_we),
        .div_i  (div_val),
        .wrap_i (car_wrap),
        .irq_o  (carrier_irq)
    );

    assign pwm_u = pwm_vec[0];
    assign pwm_v = pwm_vec[1];
    assign pwm_w = pwm_vec[2];

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (car_st == CS_IDLE) |-> (pwm_vec == '0 && !carrier_irq));

endmodule

// File: tb/tri_phase_pwm_tb_top.sv
`timescale 1ns/1ps
module tri_phase_pwm_tb_top;

    localparam int WIDTH = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic tick_en, mode_tri, dual_en, wid_we, wid_alt, div_we;
    logic [WIDTH-1:0] period_m, wid_data;
    logic [2:0] force_en, force_lvl;
    logic [1:0] wid_sel;
    logic [3:0] div_val;
    logic pwm_u, pwm_v, pwm_w, carrier_irq;

    always #2 clk = ~clk;

    tri_phase_pwm #(.WIDTH(WIDTH), .DIV_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_tri(mode_tri),
        .period_m(period_m), .dual_en(dual_en), .force_en(force_en),
        .force_lvl(force_lvl), .wid_we(wid_we), .wid_sel(wid_sel),
        .wid_alt(wid_alt), .wid_data(wid_data), .div_we(div_we),
        .div_val(div_val), .pwm_u(pwm_u), .pwm_v(pwm_v), .pwm_w(pwm_w),
        .carrier_irq(carrier_irq)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    int stg_a[3], stg_b[3], act_a[3], act_b[3];
    bit frc[3], lvl[3];
    int m_act, pos, wraps, div_set;
    bit tri_act, started, irq_exp;

    task automatic check(input int actual, input int expected, input string tag, input string what);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, actual, expected, $time);
        end
    endtask

    function automatic bit exp_out(input int i);
        int c, n;
        if (!started) return 1'b0;
        if (frc[i]) return lvl[i];
        if (tri_act) begin
            if (pos <= m_act) begin c = pos; n = act_a[i]; end
            else begin c = 2 * m_act + 1 - pos; n = act_b[i]; end
            return (c + n > m_act);
        end
        return (pos < act_a[i]);
    endfunction

    function automatic void model_load();
        m_act   = int'(period_m);
        tri_act = mode_tri;
        for (int i = 0; i < 3; i++) begin
            act_a[i] = stg_a[i];
            act_b[i] = dual_en ? stg_b[i] : stg_a[i];
            frc[i]   = force_en[i];
            lvl[i]   = force_lvl[i];
        end
    endfunction

    function automatic void model_step(input bit t);
        int per;
        int eff;
        irq_exp = 1'b0;
        if (!t) return;
        if (!started) begin
            started = 1'b1;
            pos = 0;
            model_load();
            return;
        end
        per = tri_act ? 2 * (m_act + 1) : (m_act + 1);
        pos++;
        if (pos == per) begin
            pos = 0;
            model_load();
            wraps++;
            eff = (div_set == 0) ? 1 : div_set;
            if (wraps % eff == 0) irq_exp = 1'b1;
        end
    endfunction

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; wid_we = 1'b0; div_we = 1'b0;
        wid_sel = '0; wid_alt = 1'b0; wid_data = '0; div_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            stg_a[i] = 0; stg_b[i] = 0; act_a[i] = 0; act_b[i] = 0;
            frc[i] = 0; lvl[i] = 0;
        end
        started = 0; pos = 0; wraps = 0; div_set = 0; irq_exp = 0;
        m_act = 0; tri_act = 0;
    endtask

    task automatic write_w(input int sel, input bit alt, input int val);
        @(negedge clk);
        tick_en = 1'b0; wid_we = 1'b1; wid_sel = 2'(sel); wid_alt = alt;
        wid_data = WIDTH'(val);
        @(posedge clk);
        model_step(1'b0);
        if (sel < 3) begin
            if (alt) stg_b[sel] = val;
            else     stg_a[sel] = val;
        end
        @(negedge clk);
        wid_we = 1'b0;
    endtask

    task automatic write_div(input int val);
        @(negedge clk);
        tick_en = 1'b0; div_we = 1'b1; div_val = 4'(val);
        @(posedge clk);
        model_step(1'b0);
        div_set = val; wraps = 0;
        @(negedge clk);
        div_we = 1'b0;
        check(int'(carrier_irq), 0, "R11", "irq after div write");
    endtask

    task automatic run(input int ncyc, input int spacing, input string tag);
        for (int c = 0; c < ncyc; c++) begin
            bit t;
            @(negedge clk);
            check(int'(pwm_u), int'(exp_out(0)), tag, "pwm_u");
            check(int'(pwm_v), int'(exp_out(1)), tag, "pwm_v");
            check(int'(pwm_w), int'(exp_out(2)), tag, "pwm_w");
            check(int'(carrier_irq), int'(irq_exp), tag, "carrier_irq");
            t = ((c % spacing) == 0);
            tick_en = t;
            @(posedge clk);
            model_step(t);
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; mode_tri = 1'b1; period_m = 16'd3; dual_en = 1'b0;
        force_en = '0; force_lvl = '0;

        // R3: quiet after reset until the first tick
        reset_dut();
        write_w(0, 0, 2);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(int'({pwm_u, pwm_v, pwm_w}), 0, "R3", "outputs before start");
            check(int'(carrier_irq), 0, "R3", "irq before start");
        end

        // sweep: mode x period x width, dense and sparse ticks (R1 R2 R4 R5 R6 R8 R10 R3)
        for (int md = 0; md < 2; md++) begin
            for (int m = 0; m < 5; m++) begin
                for (int n = 0; n < 7; n++) begin
                    int sp, per;
                    sp  = 1 + ((m + n) % 2);
                    reset_dut();
                    mode_tri = md[0]; period_m = WIDTH'(m);
                    dual_en  = n[0]; force_en = '0; force_lvl = '0;
                    write_w(0, 0, n);
                    write_w(1, 0, (n + 2) % 7);
                    write_w(2, 0, (n + 5) % 7);
                    write_w(0, 1, (n + 3) % 7);
                    write_w(1, 1, (n + 1) % 7);
                    write_w(2, 1, (n + 4) % 7);
                    write_div((m + n) % 5);
                    per = md ? 2 * (m + 1) : (m + 1);
                    if (md == 1) run(3 * per * sp + 2, sp, "R1 R4 R6 R8 R10 R3");
                    else         run(3 * per * sp + 2, sp, "R2 R5 R8 R10 R3");
                end
            end
        end

        // staged updates mid-run: widths, dual, force, period, mode (R7 R6 R9 R12)
        reset_dut();
        mode_tri = 1'b1; period_m = 16'd5; dual_en = 1'b0;
        write_w(0, 0, 2); write_w(1, 0, 4); write_w(2, 0, 6);
        write_div(2);
        run(17, 1, "R1 R4 R10");
        write_w(0, 0, 5);
        write_w(1, 1, 1);
        write_w(3, 0, 9);           // R7: select 3 is ignored
        dual_en = 1'b1;
        force_en = 3'b100; force_lvl = 3'b000;
        run(40, 1, "R6 R7 R9");
        force_en = 3'b011; force_lvl = 3'b010;
        run(30, 1, "R9");
        force_en = '0;
        period_m = 16'd3; mode_tri = 1'b0;
        run(25, 1, "R12 R2 R5");
        period_m = 16'd2; mode_tri = 1'b1;
        run(30, 2, "R12 R1");

        // decimation 15 and restart on write (R10 R11)
        reset_dut();
        mode_tri = 1'b0; period_m = 16'd0; dual_en = 1'b0;
        write_w(0, 0, 1);
        write_div(15);
        run(50, 1, "R10 R2");
        write_div(4);
        run(14, 1, "R11");
        write_div(3);
        run(12, 1, "R11");
        write_div(0);
        run(6, 1, "R10");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R3 actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule